// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits beside a small processor core and performs the context switch into and out of a service routine. An external interrupt line and an internal exception line share one entry path. Entry saves the core's flags word and then the address of the next instruction on a word-wide stack. It then redirects the core's program counter to a supplied handler address and clears the interrupt-enable flag. A return request from the core reverses this: the return address is popped into the program counter first, and then the saved flags word is popped back into the flags register.

The stack lives in an external single-port memory with one-cycle read latency. The sequencer owns the stack pointer. The stack grows downward: a push writes at the pointer minus one and moves the pointer there, and a pop reads at the pointer and then moves it up by one. While a sequence runs, `busy` is high and the core must not retire instructions. Requests that arrive while `busy` is high, or an external interrupt that arrives while interrupts are disabled, are held until they can be served.

Top module: `irq_frame_seq`

## Requirements
- R1: After reset `busy` is low, the stack pointer equals `SP_TOP` (default 0xF0), and no memory strobe, program counter load or flags load is asserted.
- R2: The first write of an entry stores the current flags word at address stack pointer minus one.
- R3: The second write of an entry stores the next-instruction address at the original stack pointer minus two, and the stack pointer ends two words lower.
- R4: After both pushes the program counter is loaded with the handler address, and the flags are loaded with the pushed value with the enable bit (bit `IE_BIT`, default 9) cleared. An entry keeps `busy` high for exactly 3 cycles.
- R5: A return reads the return address at the stack pointer and loads it into the program counter, then reads the flags at the stack pointer plus one and loads them. The stack pointer ends two words higher, and `busy` stays high for exactly 3 cycles.
- R6: An exception request enters through the same save and redirect sequence regardless of the enable bit, and `cause_exc` reads 1 after it; an interrupt entry leaves `cause_exc` at 0.
- R7: When an exception and an interrupt are requested in the same cycle, the exception is entered first. The interrupt stays pending and is entered once the return has restored an enabled flags word.
- R8: An external interrupt request while the enable bit is 0 starts no sequence, writes no memory and leaves the stack pointer unchanged; it is taken as soon as the enable bit becomes 1.
- R9: A request that arrives while `busy` is high is held and served after the running sequence ends.
- R10: Memory write and read strobes are never asserted together, and no strobe or load is asserted while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Internal exception request pulse |
| irq_req | input | 1 | External interrupt request pulse |
| ret_req | input | 1 | Return-from-handler request pulse from the core |
| next_pc | input | W | Address of the next instruction of the running program |
| flags_in | input | W | Current flags word of the core |
| handler_addr | input | W | Service routine start address |
| mem_we | output | 1 | Stack memory write strobe |
| mem_re | output | 1 | Stack memory read strobe |
| mem_addr | output | SPW | Stack memory word address |
| mem_wdata | output | W | Stack memory write data |
| mem_rdata | input | W | Stack memory read data, valid one cycle after `mem_re` |
| sp | output | SPW | Stack pointer |
| pc_load | output | 1 | Load strobe for the core's program counter |
| pc_value | output | W | Value to load into the program counter |
| flags_load | output | 1 | Load strobe for the core's flags register |
| flags_value | output | W | Value to load into the flags register |
| busy | output | 1 | Entry or return sequence in progress |
| cause_exc | output | 1 | 1 when the latest entry was an exception |

## Verification
The sequencer is driven with lone interrupts, lone exceptions, both in one cycle, an interrupt while the enable bit is clear, and a request injected in the middle of a running entry. Each case is followed by a return pulse, and random flags, return addresses and handler addresses separate a correct push order from a swapped one. Comparing the last two write and read addresses separates pre-decrement from post-decrement and the order of pops. Holding off an interrupt with the enable bit clear, and then enabling it, shows whether requests are dropped or merely deferred. A simultaneous request exposes the priority between exception and interrupt.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PUSH_FL,
    S_PUSH_PC,
    S_JUMP,
    S_POP_PC,
    S_POP_FL,
    S_RESTORE
  } seq_state_t;

  localparam int REQ_EXC = 0;
  localparam int REQ_IRQ = 1;
  localparam int REQ_RET = 2;
  localparam int REQ_N   = 3;

endpackage

// File: rtl/irq_req_hold.sv
module irq_req_hold #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)          pend[g] <= 1'b0;
      else if (req[g])     pend[g] <= 1'b1;
      else if (clr[g])     pend[g] <= 1'b0;
    end
  end

endmodule

// File: rtl/irq_sp_unit.sv
module irq_sp_unit #(
  parameter int               SPW    = 8,
  parameter logic [SPW-1:0]   SP_TOP = 8'hF0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           dec,
  input  logic           inc,
  output logic [SPW-1:0] sp,
  output logic [SPW-1:0] push_addr
);

  function automatic logic [SPW-1:0] f_below(input logic [SPW-1:0] p);
    return p - SPW'(1);
  endfunction

  function automatic logic [SPW-1:0] f_above(input logic [SPW-1:0] p);
    return p + SPW'(1);
  endfunction

  assign push_addr = f_below(sp);

  always_ff @(posedge clk) begin
    if (!rst_n)   sp <= SP_TOP;
    else if (dec) sp <= f_below(sp);
    else if (inc) sp <= f_above(sp);
  end

endmodule

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REQ_N-1:0] pend,
  input  logic             ie,
  output logic [REQ_N-1:0] clr,
  output logic             busy,
  output logic             cause_exc,
  output logic             accept,
  output logic             push_fl,
  output logic             push_pc,
  output logic             jump,
  output logic             pop_pc,
  output logic             pop_fl,
  output logic             restore
);

  seq_state_t state, nxt;

  always_comb begin
    nxt = state;
    clr = '0;
    unique case (state)
      S_IDLE: begin
        if (pend[REQ_EXC]) begin
          nxt          = S_PUSH_FL;
          clr[REQ_EXC] = 1'b1;
        end else if (pend[REQ_IRQ] && ie) begin
          nxt          = S_PUSH_FL;
          clr[REQ_IRQ] = 1'b1;
        end else if (pend[REQ_RET]) begin
          nxt          = S_POP_PC;
          clr[REQ_RET] = 1'b1;
        end
      end
      S_PUSH_FL: nxt = S_PUSH_PC;
      S_PUSH_PC: nxt = S_JUMP;
      S_JUMP:    nxt = S_IDLE;
      S_POP_PC:  nxt = S_POP_FL;
      S_POP_FL:  nxt = S_RESTORE;
      S_RESTORE: nxt = S_IDLE;
      default:   nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            cause_exc <= 1'b0;
    else if (clr[REQ_EXC]) cause_exc <= 1'b1;
    else if (clr[REQ_IRQ]) cause_exc <= 1'b0;
  end

  assign accept  = clr[REQ_EXC] | clr[REQ_IRQ];
  assign busy    = (state != S_IDLE);
  assign push_fl = (state == S_PUSH_FL);
  assign push_pc = (state == S_PUSH_PC);
  assign jump    = (state == S_JUMP);
  assign pop_pc  = (state == S_POP_PC);
  assign pop_fl  = (state == S_POP_FL);
  assign restore = (state == S_RESTORE);

endmodule

// File: rtl/irq_frame_seq.sv
module irq_frame_seq
  import irq_seq_pkg::*;
#(
  parameter int             W      = 16,
  parameter int             SPW    = 8,
  parameter int             IE_BIT = 9,
  parameter logic [SPW-1:0] SP_TOP = 8'hF0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           exc_req,
  input  logic           irq_req,
  input  logic           ret_req,
  input  logic [W-1:0]   next_pc,
  input  logic [W-1:0]   flags_in,
  input  logic [W-1:0]   handler_addr,
  output logic           mem_we,
  output logic           mem_re,
  output logic [SPW-1:0] mem_addr,
  output logic [W-1:0]   mem_wdata,
  input  logic [W-1:0]   mem_rdata,
  output logic [SPW-1:0] sp,
  output logic           pc_load,
  output logic [W-1:0]   pc_value,
  output logic           flags_load,
  output logic [W-1:0]   flags_value,
  output logic           busy,
  output logic           cause_exc
);

  function automatic logic [W-1:0] f_mask_ie(input logic [W-1:0] f);
    logic [W-1:0] m;
    m         = '1;
    m[IE_BIT] = 1'b0;
    return f & m;
  endfunction

  logic [REQ_N-1:0] req_vec, clr_vec, pend_vec;
  logic             accept, push_fl, push_pc, jump, pop_pc, pop_fl, restore;
  logic [SPW-1:0]   push_addr;

  always_comb begin
    req_vec          = '0;
    req_vec[REQ_EXC] = exc_req;
    req_vec[REQ_IRQ] = irq_req;
    req_vec[REQ_RET] = ret_req;
  end

  irq_req_hold #(.N(REQ_N)) u_hold (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (req_vec),
    .clr  (clr_vec),
    .pend (pend_vec)
  );

  irq_seq_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend     (pend_vec),
    .ie       (flags_in[IE_BIT]),
    .clr      (clr_vec),
    .busy     (busy),
    .cause_exc(cause_exc),
    .accept   (accept),
    .push_fl  (push_fl),
    .push_pc  (push_pc),
    .jump     (jump),
    .pop_pc   (pop_pc),
    .pop_fl   (pop_fl),
    .restore  (restore)
  );

  irq_sp_unit #(.SPW(SPW), .SP_TOP(SP_TOP)) u_sp (
    .clk      (clk),
    .rst_n    (rst_n),
    .dec      (mem_we),
    .inc      (mem_re),
    .sp       (sp),
    .push_addr(push_addr)
  );

  assign mem_we      = push_fl | push_pc;
  assign mem_re      = pop_pc | pop_fl;
  assign mem_addr    = mem_we ? push_addr : sp;
  assign mem_wdata   = push_fl ? flags_in : next_pc;

  // pop_fl is the cycle in which the popped return address arrives
  assign pc_load     = jump | pop_fl;
  assign pc_value    = jump ? handler_addr : mem_rdata;
  assign flags_load  = jump | restore;
  assign flags_value = jump ? f_mask_ie(flags_in) : mem_rdata;

endmodule

// File: rtl/irq_frame_seq_chk.sv
module irq_frame_seq_chk #(
  parameter int             W      = 16,
  parameter int             SPW    = 8,
  parameter int             IE_BIT = 9,
  parameter logic [SPW-1:0] SP_TOP = 8'hF0
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic [SPW-1:0] sp,
  input logic           mem_we,
  input logic           mem_re,
  input logic           pc_load,
  input logic [W-1:0]   pc_value,
  input logic [W-1:0]   handler_addr,
  input logic           flags_load,
  input logic [W-1:0]   flags_value,
  input logic           cause_exc,
  input logic           push_fl,
  input logic           push_pc,
  input logic           jump,
  input logic           pop_pc,
  input logic           pop_fl,
  input logic           accept,
  input logic           exc_pend
);

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!busy && sp == SP_TOP));

  p_flags_then_pc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push_fl |=> push_pc);

  p_push_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (sp == SPW'($past(sp) - SPW'(1))));

  p_jump_after_push_r4: assert property (@(posedge clk) disable iff (!rst_n)
    push_pc |=> (pc_load && pc_value == handler_addr));

  p_ie_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    jump |-> (flags_load && !flags_value[IE_BIT]));

  p_pc_then_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop_pc |=> (pop_fl && pc_load));

  p_pop_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> (sp == SPW'($past(sp) + SPW'(1))));

  p_exc_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && exc_pend) |=> cause_exc);

  p_one_port_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(mem_we || mem_re || pc_load || flags_load));

endmodule

bind irq_frame_seq irq_frame_seq_chk #(
  .W(W), .SPW(SPW), .IE_BIT(IE_BIT), .SP_TOP(SP_TOP)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .sp          (sp),
  .mem_we      (mem_we),
  .mem_re      (mem_re),
  .pc_load     (pc_load),
  .pc_value    (pc_value),
  .handler_addr(handler_addr),
  .flags_load  (flags_load),
  .flags_value (flags_value),
  .cause_exc   (cause_exc),
  .push_fl     (push_fl),
  .push_pc     (push_pc),
  .jump        (jump),
  .pop_pc      (pop_pc),
  .pop_fl      (pop_fl),
  .accept      (accept),
  .exc_pend    (pend_vec[0])
);

// File: tb/irq_frame_seq_bench.sv
`timescale 1ns/1ps
module irq_frame_seq_bench;
  localparam int             W   = 16;
  localparam int             SPW = 8;
  localparam int             IE  = 9;
  localparam logic [SPW-1:0] TOP = 8'hF0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic exc_req = 1'b0, irq_req = 1'b0, ret_req = 1'b0;
  logic [W-1:0] next_pc = '0, handler = '0;
  logic [W-1:0] core_pc = '0, core_flags = '0;
  logic [W-1:0] mem_wdata, mem_rdata = '0, pc_value, flags_value;
  logic [SPW-1:0] mem_addr, sp;
  logic mem_we, mem_re, pc_load, flags_load, busy, cause_exc;
  logic set_req = 1'b0;
  logic [W-1:0] set_val = '0;

  logic [W-1:0]   stk [0:255];
  logic [SPW-1:0] wa_prev = '0, wa_last = '0, ra_prev = '0, ra_last = '0;
  logic [W-1:0]   wd_prev = '0, wd_last = '0;
  int wr_total = 0, rd_total = 0, port_viol = 0;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  irq_frame_seq u_irq_frame_seq (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .irq_req(irq_req),
    .ret_req(ret_req), .next_pc(next_pc), .flags_in(core_flags),
    .handler_addr(handler), .mem_we(mem_we), .mem_re(mem_re),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .sp(sp), .pc_load(pc_load), .pc_value(pc_value),
    .flags_load(flags_load), .flags_value(flags_value), .busy(busy),
    .cause_exc(cause_exc)
  );

  // stack RAM and core register model
  always @(posedge clk) begin
    if (mem_we) begin
      stk[mem_addr] <= mem_wdata;
      wa_prev <= wa_last; wd_prev <= wd_last;
      wa_last <= mem_addr; wd_last <= mem_wdata;
      wr_total <= wr_total + 1;
    end
    if (mem_re) begin
      mem_rdata <= stk[mem_addr];
      ra_prev <= ra_last; ra_last <= mem_addr;
      rd_total <= rd_total + 1;
    end
    if (pc_load) core_pc <= pc_value;
    if (flags_load) core_flags <= flags_value;
    else if (set_req) core_flags <= set_val;
    if (rst_n && ((mem_we && mem_re) || (!busy && (mem_we || mem_re || pc_load || flags_load))))
      port_viol <= port_viol + 1;
  end

  function automatic logic [W-1:0] no_ie(input logic [W-1:0] f);
    return f & ~(W'(1) << IE);
  endfunction

  function automatic logic [W-1:0] with_ie(input logic [W-1:0] f);
    return f | (W'(1) << IE);
  endfunction

  task automatic chk(input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic set_flags(input logic [W-1:0] f);
    @(negedge clk); set_req = 1'b1; set_val = f;
    @(negedge clk); set_req = 1'b0;
  endtask

  task automatic pulse(input bit e, input bit i, input bit r);
    @(negedge clk); exc_req = e; irq_req = i; ret_req = r;
    @(negedge clk); exc_req = 1'b0; irq_req = 1'b0; ret_req = 1'b0;
  endtask

  // waits for a sequence to start and returns its busy length in cycles
  task automatic run_seq(output int cycles);
    int g = 0;
    cycles = 0;
    while (!busy && g < 20) begin @(negedge clk); g++; end
    if (!busy) return;
    while (busy && cycles < 40) begin @(negedge clk); cycles++; end
  endtask

  task automatic entry_chk(input string rq, input bit exp_exc, input logic [W-1:0] f,
                           input logic [W-1:0] pc, input logic [W-1:0] h,
                           input logic [SPW-1:0] sp0);
    int base = wr_total;
    int cyc;
    run_seq(cyc);
    chk({rq, " R4"}, "entry busy cycles", cyc, 3);
    chk({rq, " R3"}, "write count", wr_total - base, 2);
    chk({rq, " R2"}, "first write addr", int'(wa_prev), int'(SPW'(sp0 - 1)));
    chk({rq, " R2"}, "first write data flags", int'(wd_prev), int'(f));
    chk({rq, " R3"}, "second write addr", int'(wa_last), int'(SPW'(sp0 - 2)));
    chk({rq, " R3"}, "second write data pc", int'(wd_last), int'(pc));
    chk({rq, " R3"}, "sp after entry", int'(sp), int'(SPW'(sp0 - 2)));
    chk({rq, " R4"}, "pc = handler", int'(core_pc), int'(h));
    chk({rq, " R4"}, "flags ie cleared", int'(core_flags), int'(no_ie(f)));
    chk({rq, " R6"}, "cause_exc", int'(cause_exc), int'(exp_exc));
  endtask

  task automatic ret_chk(input string rq, input logic [W-1:0] pc,
                         input logic [W-1:0] f, input logic [SPW-1:0] sp0);
    int base = rd_total;
    int cyc;
    pulse(1'b0, 1'b0, 1'b1);
    run_seq(cyc);
    chk({rq, " R5"}, "return busy cycles", cyc, 3);
    chk({rq, " R5"}, "read count", rd_total - base, 2);
    chk({rq, " R5"}, "first read addr", int'(ra_prev), int'(sp0));
    chk({rq, " R5"}, "second read addr", int'(ra_last), int'(SPW'(sp0 + 1)));
    chk({rq, " R5"}, "pc restored", int'(core_pc), int'(pc));
    chk({rq, " R5"}, "flags restored", int'(core_flags), int'(f));
    chk({rq, " R5"}, "sp after return", int'(sp), int'(SPW'(sp0 + 2)));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    logic [W-1:0] f, pc1, pc2, h;
    int seed_v, busy_seen, kind;
    seed_v = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "busy in reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "busy after reset", int'(busy), 0);
    chk("R1", "sp after reset", int'(sp), int'(TOP));
    chk("R1", "strobes after reset", int'({mem_we, mem_re, pc_load, flags_load}), 0);

    // directed interrupt entry and return
    f = 16'h0235; pc1 = 16'h1234; h = 16'h8000;
    set_flags(f); next_pc = pc1; handler = h;
    pulse(1'b0, 1'b1, 1'b0);
    entry_chk("R2 irq", 1'b0, f, pc1, h, TOP);
    next_pc = 16'h5555;
    ret_chk("R5 irq", pc1, f, TOP - 2);

    // R6 exception taken with enable bit clear
    f = 16'h0011; pc1 = 16'h4321; h = 16'h9100;
    set_flags(f); next_pc = pc1; handler = h;
    pulse(1'b1, 1'b0, 1'b0);
    entry_chk("R6 exc", 1'b1, f, pc1, h, TOP);
    ret_chk("R6 exc", pc1, f, TOP - 2);

    // R8 interrupt held off while disabled
    f = 16'h0003; pc1 = 16'h2468; h = 16'hA000;
    set_flags(f); next_pc = pc1; handler = h;
    pulse(1'b0, 1'b1, 1'b0);
    busy_seen = 0;
    for (int k = 0; k < 10; k++) begin @(negedge clk); if (busy) busy_seen++; end
    chk("R8", "no sequence while disabled", busy_seen, 0);
    chk("R8", "sp unchanged while disabled", int'(sp), int'(TOP));
    chk("R8", "pc unchanged while disabled", int'(core_pc), int'(16'h4321));
    f = with_ie(f);
    set_flags(f);
    entry_chk("R8 deferred", 1'b0, f, pc1, h, TOP);
    ret_chk("R8 deferred", pc1, f, TOP - 2);

    // R7 simultaneous requests: exception first
    f = 16'h02F0; pc1 = 16'h1111; pc2 = 16'h2222; h = 16'hB000;
    set_flags(f); next_pc = pc1; handler = h;
    pulse(1'b1, 1'b1, 1'b0);
    entry_chk("R7 exc first", 1'b1, f, pc1, h, TOP);
    next_pc = pc2;
    ret_chk("R7", pc1, f, TOP - 2);
    entry_chk("R7 irq second", 1'b0, f, pc2, h, TOP);
    ret_chk("R7", pc2, f, TOP - 2);

    // R9 exception arriving during a running entry
    f = 16'h0207; pc1 = 16'h3333; pc2 = 16'h4444; h = 16'hC000;
    set_flags(f); next_pc = pc1; handler = h;
    pulse(1'b0, 1'b1, 1'b0);
    while (!busy) @(negedge clk);
    pulse(1'b1, 1'b0, 1'b0);
    while (busy) @(negedge clk);
    chk("R9", "first entry pc", int'(core_pc), int'(h));
    next_pc = pc2;
    entry_chk("R9 held exc", 1'b1, no_ie(f), pc2, h, TOP - 2);
    ret_chk("R9 inner", pc2, no_ie(f), TOP - 4);
    ret_chk("R9 outer", pc1, f, TOP - 2);

    // random entries
    for (int it = 0; it < 30; it++) begin
      f   = with_ie(W'($urandom()));
      pc1 = W'($urandom());
      pc2 = W'($urandom());
      h   = W'($urandom());
      kind = $urandom_range(0, 2);
      set_flags(f); next_pc = pc1; handler = h;
      if (kind == 0) begin
        pulse(1'b0, 1'b1, 1'b0);
        entry_chk("R2 rnd irq", 1'b0, f, pc1, h, TOP);
        ret_chk("R5 rnd", pc1, f, TOP - 2);
      end else if (kind == 1) begin
        pulse(1'b1, 1'b0, 1'b0);
        entry_chk("R6 rnd exc", 1'b1, f, pc1, h, TOP);
        ret_chk("R5 rnd", pc1, f, TOP - 2);
      end else begin
        pulse(1'b1, 1'b1, 1'b0);
        entry_chk("R7 rnd both", 1'b1, f, pc1, h, TOP);
        next_pc = pc2;
        ret_chk("R7 rnd", pc1, f, TOP - 2);
        entry_chk("R7 rnd irq", 1'b0, f, pc2, h, TOP);
        ret_chk("R7 rnd", pc2, f, TOP - 2);
      end
    end

    chk("R10", "port and idle strobe violations", port_viol, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule